// File: doc/BRIEF.md
# Wormhole Output Port Allocator

This block sits between the per-direction flit buffers of a four-port switch and its four output links. Each buffer shows the flit at its head, with header and tail marks, and a header flit also carries the index of the output port it wants. The allocator gives each output port to one packet at a time. The header flit takes the port, the payload flits follow on the same path, and the tail flit gives the port back. Every buffer can reach every output port at the same time, as long as the ports it targets differ.

When several headers compete for the same free port, a round-robin pointer kept for each port picks the winner. A buffer is popped only in the cycle in which its flit is taken by a ready output. Packets that lose arbitration, or that want a port another packet holds, wait in their buffers. Packets of any length pass through in order, one flit per cycle when the output is ready.

Top module: `wh_port_alloc`

## Requirements
- R1: After reset every output port is free, no output valid is high and no buffer is popped.
- R2: A header flit that wants a free port is driven onto that port in the same cycle it reaches its buffer head, and the port becomes owned by that buffer.
- R3: An owned port stays with its owner until the owner's tail flit is accepted on it. Headers from other buffers that want this port are not popped while it is owned.
- R4: While a port is owned, only flits from the owning buffer appear on it. A non-header flit is never driven onto a port its buffer does not own.
- R5: A buffer's pop is high only in a cycle in which its flit is shown valid on a port whose ready is high. With ready low, the same flit stays on the port and nothing is popped.
- R6: Packets from different buffers to different ports move in the same cycle.
- R7: Competing headers for a free port are granted in round-robin order. The pointer of each port starts at buffer 0, the search runs upward from the pointer and wraps, and after a grant the pointer moves to one past the winner.
- R8: A flit marked both header and tail, when accepted, takes and frees its port in the same cycle, so the next packet can win the port in the following cycle.
- R9: Packets of 32 and 64 flits arrive complete and in order, with no flit of another packet between their header and their tail.
- R10: A port carrying no flit drives valid low and zero data, header and tail.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| buf_valid | input | NPORT | Buffer head holds a flit |
| buf_data | input | NPORT*DW | Head flit data, buffer b at bits [b*DW +: DW] |
| buf_head | input | NPORT | Head flit is a header |
| buf_tail | input | NPORT | Head flit is a tail |
| buf_dest | input | NPORT*PW | Wanted output port of a header, buffer b at [b*PW +: PW] |
| buf_pop | output | NPORT | Head flit taken this cycle |
| port_valid | output | NPORT | Output port carries a flit |
| port_data | output | NPORT*DW | Output flit data, port p at [p*DW +: DW] |
| port_head | output | NPORT | Output flit is a header |
| port_tail | output | NPORT | Output flit is a tail |
| port_ready | input | NPORT | Output link accepts a flit |

## Verification
A stuck or wrong owner shows at once at the ports. Payload flits appear on a port behind a header from a different buffer, or a waiting header is popped while another packet still holds the port, so the order of flits recorded on that port is broken within one or two cycles. A release that is missed leaves the port silent after a tail flit has gone, and the next drain stalls. A pointer that does not move changes which of two competing headers appears first, and this shows in the very next contest for that port.

// File: rtl/wh_port_alloc.sv
module wh_port_alloc #(
  parameter int NPORT = 4,
  parameter int DW    = 16,
  parameter int PW    = (NPORT > 1) ? $clog2(NPORT) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NPORT-1:0]    buf_valid,
  input  logic [NPORT*DW-1:0] buf_data,
  input  logic [NPORT-1:0]    buf_head,
  input  logic [NPORT-1:0]    buf_tail,
  input  logic [NPORT*PW-1:0] buf_dest,
  output logic [NPORT-1:0]    buf_pop,
  output logic [NPORT-1:0]    port_valid,
  output logic [NPORT*DW-1:0] port_data,
  output logic [NPORT-1:0]    port_head,
  output logic [NPORT-1:0]    port_tail,
  input  logic [NPORT-1:0]    port_ready
);

  logic [NPORT-1:0] own_vld;
  logic [PW-1:0]    own_src [NPORT];
  logic [PW-1:0]    rr_ptr  [NPORT];

  logic [NPORT-1:0] grant;
  logic [PW-1:0]    win     [NPORT];
  logic [PW-1:0]    sel_src [NPORT];
  logic [NPORT-1:0] xfer;

  always_comb begin
    for (int p = 0; p < NPORT; p++) begin
      logic [NPORT-1:0] req;
      logic found;
      req = '0;
      found = 1'b0;
      win[p] = '0;
      for (int b = 0; b < NPORT; b++)
        req[b] = buf_valid[b] && buf_head[b] && (buf_dest[b*PW +: PW] == PW'(p));
      for (int k = 0; k < NPORT; k++) begin
        int idx;
        idx = (int'(rr_ptr[p]) + k) % NPORT;
        if (!found && req[idx]) begin
          found = 1'b1;
          win[p] = PW'(idx);
        end
      end
      grant[p]   = !own_vld[p] && found;
      sel_src[p] = own_vld[p] ? own_src[p] : win[p];
      port_valid[p] = own_vld[p] ? buf_valid[own_src[p]] : found;
      port_data[p*DW +: DW] = port_valid[p] ? buf_data[sel_src[p]*DW +: DW] : '0;
      port_head[p] = port_valid[p] && buf_head[sel_src[p]];
      port_tail[p] = port_valid[p] && buf_tail[sel_src[p]];
      xfer[p] = port_valid[p] && port_ready[p];
    end
  end

  always_comb begin
    buf_pop = '0;
    for (int p = 0; p < NPORT; p++)
      if (xfer[p]) buf_pop[sel_src[p]] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      own_vld <= '0;
      for (int p = 0; p < NPORT; p++) begin
        own_src[p] <= '0;
        rr_ptr[p]  <= '0;
      end
    end else begin
      for (int p = 0; p < NPORT; p++) begin
        if (grant[p]) begin
          rr_ptr[p]  <= PW'((int'(win[p]) + 1) % NPORT);
          own_src[p] <= win[p];
          own_vld[p] <= !(xfer[p] && port_tail[p]);
        end else if (own_vld[p] && xfer[p] && port_tail[p]) begin
          own_vld[p] <= 1'b0;
        end
      end
    end
  end

  p_pop_matches_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(buf_pop) == $countones(port_valid & port_ready));

  for (genvar g = 0; g < NPORT; g++) begin : g_chk
    p_hold_owner_r3: assert property (@(posedge clk) disable iff (!rst_n)
      own_vld[g] && !(port_valid[g] && port_ready[g] && port_tail[g])
      |=> own_vld[g] && own_src[g] == $past(own_src[g]));
    p_payload_owned_r4: assert property (@(posedge clk) disable iff (!rst_n)
      port_valid[g] && !port_head[g] |-> own_vld[g]);
    p_tail_frees_r8: assert property (@(posedge clk) disable iff (!rst_n)
      port_valid[g] && port_ready[g] && port_tail[g] |=> !own_vld[g]);
    p_header_claims_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !own_vld[g] && port_valid[g] && !(port_ready[g] && port_tail[g]) |=> own_vld[g]);
    p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !port_valid[g] |-> port_data[g*DW +: DW] == '0 && !port_head[g] && !port_tail[g]);
  end

endmodule

// File: tb/wh_port_alloc_tb.sv
module wh_port_alloc_tb;
  localparam int N = 4;
  localparam int DW = 16;
  localparam int PW = 2;
  localparam int DEPTH = 512;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0]    buf_valid, buf_head, buf_tail, buf_pop;
  logic [N*DW-1:0] buf_data;
  logic [N*PW-1:0] buf_dest;
  logic [N-1:0]    port_valid, port_head, port_tail;
  logic [N*DW-1:0] port_data;
  logic [N-1:0]    port_ready = '0;

  wh_port_alloc #(.NPORT(N), .DW(DW), .PW(PW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .buf_valid(buf_valid), .buf_data(buf_data), .buf_head(buf_head),
    .buf_tail(buf_tail), .buf_dest(buf_dest), .buf_pop(buf_pop),
    .port_valid(port_valid), .port_data(port_data), .port_head(port_head),
    .port_tail(port_tail), .port_ready(port_ready)
  );

  always #5 clk = ~clk;

  logic [DW-1:0] bdat [N][DEPTH];
  logic          bhd  [N][DEPTH];
  logic          btl  [N][DEPTH];
  logic [PW-1:0] bds  [N][DEPTH];
  int wr [N] = '{default: 0};
  int rd [N] = '{default: 0};
  logic [N-1:0] pop_q = '0;
  logic [DW-1:0] rx [N][DEPTH];
  int rxn [N] = '{default: 0};
  int n_chk = 0, n_fail = 0;

  always_comb begin
    for (int b = 0; b < N; b++) begin
      buf_valid[b] = rd[b] < wr[b];
      buf_data[b*DW +: DW] = buf_valid[b] ? bdat[b][rd[b]] : '0;
      buf_head[b] = buf_valid[b] ? bhd[b][rd[b]] : 1'b0;
      buf_tail[b] = buf_valid[b] ? btl[b][rd[b]] : 1'b0;
      buf_dest[b*PW +: PW] = buf_valid[b] ? bds[b][rd[b]] : '0;
    end
  end

  always @(negedge clk) begin
    pop_q <= buf_pop;
    for (int p = 0; p < N; p++)
      if (port_valid[p] && port_ready[p]) begin
        rx[p][rxn[p]] <= port_data[p*DW +: DW];
        rxn[p] <= rxn[p] + 1;
      end
  end

  always @(posedge clk)
    for (int b = 0; b < N; b++)
      if (pop_q[b]) rd[b] <= rd[b] + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic push(input int b, input int dest, input int len, input int base);
    for (int i = 0; i < len; i++) begin
      bdat[b][wr[b]+i] = DW'(base + i);
      bhd[b][wr[b]+i]  = (i == 0);
      btl[b][wr[b]+i]  = (i == len - 1);
      bds[b][wr[b]+i]  = PW'(dest);
    end
    wr[b] = wr[b] + len;
  endtask

  task automatic drain();
    for (int c = 0; c < 400; c++) begin
      if (rd == wr) break;
      @(posedge clk);
    end
    @(posedge clk); #1;
  endtask

  task automatic check_seq(input int p, input int at, input int base, input int len, input string tag);
    for (int i = 0; i < len; i++)
      chk(rx[p][at+i] == DW'(base + i), tag, int'(rx[p][at+i]), base + i);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(port_valid == '0, "R1 no valid after reset", int'(port_valid), 0);
    chk(buf_pop == '0, "R1 no pop after reset", int'(buf_pop), 0);
    chk(port_data == '0 && port_head == '0 && port_tail == '0, "R10 idle ports zero",
        int'(port_data[15:0]), 0);
  endtask

  task automatic t_single();
    int m;
    m = rxn[2];
    push(0, 2, 4, 'h200);
    @(negedge clk);
    chk(port_valid[2] && port_head[2], "R2 header on free port same cycle", int'(port_valid), 4);
    chk(port_data[2*DW +: DW] == 16'h200, "R2 header data", int'(port_data[2*DW +: DW]), 'h200);
    chk(port_valid[0] == 1'b0, "R10 other port idle", int'(port_valid[0]), 0);
    drain();
    chk(rxn[2] - m == 4, "R9 short packet length", rxn[2] - m, 4);
    check_seq(2, m, 'h200, 4, "R9 short packet data");
  endtask

  task automatic t_round_robin();
    int m;
    push(2, 0, 1, 'h2F0);
    drain();
    m = rxn[0];
    push(0, 0, 2, 'h300);
    push(3, 0, 2, 'h330);
    @(posedge clk); @(negedge clk);
    chk(port_data[0 +: DW] == 16'h331 && !port_head[0], "R4 owner payload follows",
        int'(port_data[0 +: DW]), 'h331);
    chk(rd[0] == wr[0] - 2, "R3 blocked header not popped", rd[0], wr[0] - 2);
    drain();
    chk(rx[0][m] == 16'h330, "R7 pointer past last winner picks buffer 3",
        int'(rx[0][m]), 'h330);
    check_seq(0, m + 1, 'h331, 1, "R3 packet unbroken");
    check_seq(0, m + 2, 'h300, 2, "R3 waiting packet after release");
  endtask

  task automatic t_stall();
    int m, r0;
    m = rxn[1];
    r0 = rd[0];
    port_ready = 4'b1101;
    push(0, 1, 2, 'h400);
    push(2, 1, 1, 'h420);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk(port_valid[1] && port_data[DW +: DW] == 16'h400, "R5 flit held while not ready",
          int'(port_data[DW +: DW]), 'h400);
    end
    chk(rd[0] == r0 && rd[2] == wr[2] - 1, "R5 no pop without ready", rd[0], r0);
    @(posedge clk); #1;
    port_ready = '1;
    drain();
    check_seq(1, m, 'h400, 2, "R3 held port");
    check_seq(1, m + 2, 'h420, 1, "R3 other header after tail");
  endtask

  task automatic t_one_flit();
    int m;
    m = rxn[1];
    push(0, 1, 1, 'h500);
    push(0, 1, 1, 'h501);
    push(1, 1, 1, 'h510);
    @(posedge clk); @(posedge clk); @(posedge clk); #1;
    chk(rxn[1] - m == 3, "R8 one-flit packets back to back", rxn[1] - m, 3);
    chk(rx[1][m] == 16'h500, "R8 first one-flit", int'(rx[1][m]), 'h500);
    chk(rx[1][m+1] == 16'h510, "R7 rotation to buffer 1", int'(rx[1][m+1]), 'h510);
    chk(rx[1][m+2] == 16'h501, "R8 second one-flit", int'(rx[1][m+2]), 'h501);
    drain();
  endtask

  task automatic t_parallel();
    int m [N];
    for (int p = 0; p < N; p++) m[p] = rxn[p];
    for (int b = 0; b < N; b++) push(b, N - 1 - b, 3, 'h600 + 'h10 * b);
    @(negedge clk);
    chk(port_valid == 4'hF, "R6 four ports move together", int'(port_valid), 'hF);
    chk(buf_pop == 4'hF, "R6 four pops together", int'(buf_pop), 'hF);
    drain();
    for (int b = 0; b < N; b++)
      check_seq(N - 1 - b, m[N-1-b], 'h600 + 'h10 * b, 3, "R6 parallel data");
  endtask

  task automatic t_long();
    int m0, m3;
    m0 = rxn[0];
    m3 = rxn[3];
    push(2, 0, 32, 'h1000);
    push(0, 0, 64, 'h2000);
    push(1, 3, 64, 'h3000);
    drain();
    chk(rxn[0] - m0 == 96, "R9 port 0 total", rxn[0] - m0, 96);
    check_seq(0, m0, 'h2000, 64, "R9 64-flit packet");
    check_seq(0, m0 + 64, 'h1000, 32, "R9 32-flit packet");
    check_seq(3, m3, 'h3000, 64, "R9 64-flit on other port");
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    @(posedge clk); #1;
    port_ready = '1;
    t_single();
    t_round_robin();
    t_stall();
    t_one_flit();
    t_parallel();
    t_long();
    summary();
    $finish;
  end
endmodule